// File: doc/BRIEF.md
# Serial-to-Parallel LED Shift Controller

This peripheral drives a chain of external serial-in, parallel-out shift registers, usually feeding status LEDs. It keeps an output image of up to three 8-bit groups. On each transfer it clocks the enabled part of that image out on a shift clock and a serial data line. It then pulses a store strobe so that all parallel outputs change together.

A CPU configures the block and loads the image through a small word-addressed register interface. A transfer starts in one of two ways. The CPU can set a one-shot update request bit, which the block clears once the frame has gone out. A free-running timer can also start transfers at one of four fixed rates. Some low-order image bits can be handed to hardware status inputs instead of the CPU data register. Those inputs come from a modem core and from two Ethernet PHYs.

Top module: `stp_led_ctrl`

## Requirements
- R1: Reset state: the control-0 word (word 0) reads 0x8000_0000, and control 1 (word 1), data 0 (word 2), data 1 (word 3) and the status word (word 4) read zero. The store strobe is low.
- R2: Writing control 0 with bit 31 set starts exactly one frame. Bit 31 reads back as 0 once that frame ends. Status word bit 0 reads 1 while a frame is in flight.
- R3: The frame length is 8 × (index of the highest set bit of control 1 [2:0] + 1), and the frame carries the low bits of the image. If no group is enabled, an update request produces no frame and bit 31 still clears.
- R4: Bits leave most-significant first. The store strobe rises one half shift period after the active edge of the last bit. It stays high for one full shift period, and the shift clock stays idle during it.
- R5: Control 0 bit 26 selects the active edge. With 0 the shift clock idles low and registers clock on its rising edge. With 1 it idles high and registers clock on its falling edge.
- R6: Control 0 bits [25:24] give image bits 1:0 to the modem status input, one bit each. Where a field bit is 0, the CPU data bit is used and the status input has no effect.
- R7: Control 0 bits [28:27] give image bits 3:2 to PHY1 status [1:0]. Control 1 bits [16:15] give image bits 6:5 to PHY2 status [1:0].
- R8: Periodic updates run only when control 1 [31:30] equals 2. Control 1 [24:23] then selects a period of CLK_HZ/2, CLK_HZ/4, CLK_HZ/8 or CLK_HZ/10 system cycles for codes 0 to 3.
- R9: A timer tick that arrives while a frame is in flight is dropped. No frame is queued for it.
- R10: One shift period is 2 × HALF system cycles. Serial data is stable while the shift clock is in its active half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| modem_sts | input | 2 | Modem status for image bits 1:0 |
| phy1_sts | input | 2 | PHY1 status for image bits 3:2 |
| phy2_sts | input | 2 | PHY2 status for image bits 6:5 |
| sh_clk | output | 1 | Shift clock to the register chain |
| sh_data | output | 1 | Serial data |
| sh_store | output | 1 | Store (latch) strobe |

## Verification
The bench builds the block with CLK_HZ = 400 and HALF = 1. At these values the four timer periods are 200, 100, 50 and 40 cycles, and a 24-bit frame lasts 50 cycles. Every rate code can therefore be measured exactly from the spacing of store pulses. The fastest rate running alongside a 24-bit frame forces ticks to land mid-frame, which shows the dropped-tick behaviour as an 80-cycle gap. The one-cycle half period also makes the bit spacing and the store delay exact cycle counts.

// File: rtl/stp_pkg.sv
package stp_pkg;
    typedef enum logic [1:0] {
        SER_IDLE,
        SER_SHIFT,
        SER_STORE
    } ser_state_e;

    localparam logic [2:0] REG_CTRL0 = 3'd0;
    localparam logic [2:0] REG_CTRL1 = 3'd1;
    localparam logic [2:0] REG_DATA0 = 3'd2;
    localparam logic [2:0] REG_DATA1 = 3'd3;
    localparam logic [2:0] REG_STAT  = 3'd4;
endpackage

// File: rtl/stp_regs.sv
module stp_regs
    import stp_pkg::*;
#(
    parameter int GROUPS = 3,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    output logic              cfg_sw,
    output logic              cfg_edge,
    output logic [1:0]        cfg_modem,
    output logic [1:0]        cfg_phy1,
    output logic [1:0]        cfg_phy2,
    output logic [GROUPS-1:0] cfg_groups,
    output logic              cfg_auto,
    output logic [1:0]        cfg_rate,
    output logic [DATA_W-1:0] cfg_image
);
    typedef struct packed {
        logic [31:0] ctrl0;
        logic [31:0] ctrl1;
        logic [31:0] data0;
        logic [31:0] data1;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (done) r_d.ctrl0[31] = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL0: r_d.ctrl0 = bus_wdata;
                REG_CTRL1: r_d.ctrl1 = bus_wdata;
                REG_DATA0: r_d.data0 = bus_wdata;
                REG_DATA1: r_d.data1 = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.ctrl0 <= 32'h8000_0000;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL0: bus_rdata = r_q.ctrl0;
            REG_CTRL1: bus_rdata = r_q.ctrl1;
            REG_DATA0: bus_rdata = r_q.data0;
            REG_DATA1: bus_rdata = r_q.data1;
            REG_STAT:  bus_rdata = {31'd0, busy};
            default:   bus_rdata = '0;
        endcase
    end

    assign cfg_sw     = r_q.ctrl0[31];
    assign cfg_edge   = r_q.ctrl0[26];
    assign cfg_modem  = r_q.ctrl0[25:24];
    assign cfg_phy1   = r_q.ctrl0[28:27];
    assign cfg_phy2   = r_q.ctrl1[16:15];
    assign cfg_groups = r_q.ctrl1[GROUPS-1:0];
    assign cfg_auto   = (r_q.ctrl1[31:30] == 2'b10);
    assign cfg_rate   = r_q.ctrl1[24:23];
    assign cfg_image  = r_q.data0[DATA_W-1:0];
endmodule

// File: rtl/stp_auto_timer.sv
module stp_auto_timer #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int CNT_W = $clog2(CLK_HZ / 2 + 1);
    localparam logic [CNT_W-1:0] PER0 = CNT_W'(CLK_HZ / 2 - 1);
    localparam logic [CNT_W-1:0] PER1 = CNT_W'(CLK_HZ / 4 - 1);
    localparam logic [CNT_W-1:0] PER2 = CNT_W'(CLK_HZ / 8 - 1);
    localparam logic [CNT_W-1:0] PER3 = CNT_W'(CLK_HZ / 10 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        case (rate)
            2'd0:    last = PER0;
            2'd1:    last = PER1;
            2'd2:    last = PER2;
            default: last = PER3;
        endcase
        t_d  = t_q;
        tick = 1'b0;
        if (!enable) begin
            t_d.cnt = '0;
        end else if (t_q.cnt >= last) begin
            tick    = 1'b1;
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/stp_serializer.sv
module stp_serializer
    import stp_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int HALF   = 8,
    localparam int IDX_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] image,
    input  logic [IDX_W-1:0]  nbits,
    input  logic              edge_fall,
    output logic              busy,
    output logic              done,
    output logic              sh_clk,
    output logic              sh_data,
    output logic              sh_store
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        ser_state_e        st;
        logic [CNT_W-1:0]  hcnt;
        logic              ph;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sreg;
    } ser_t;

    ser_t s_d, s_q;
    logic half_end, slot_end;

    always_comb begin
        s_d      = s_q;
        done     = 1'b0;
        half_end = (s_q.hcnt == CNT_W'(HALF - 1));
        slot_end = half_end & s_q.ph;
        if (s_q.st == SER_IDLE) begin
            if (start) begin
                if (nbits == '0) begin
                    done = 1'b1;
                end else begin
                    s_d.st   = SER_SHIFT;
                    s_d.hcnt = '0;
                    s_d.ph   = 1'b0;
                    s_d.idx  = nbits - IDX_W'(1);
                    s_d.sreg = image << (IDX_W'(DATA_W) - nbits);
                end
            end
        end else begin
            if (half_end) begin
                s_d.hcnt = '0;
                s_d.ph   = ~s_q.ph;
            end else begin
                s_d.hcnt = s_q.hcnt + CNT_W'(1);
            end
            if (slot_end) begin
                if (s_q.st == SER_SHIFT) begin
                    if (s_q.idx == '0) begin
                        s_d.st = SER_STORE;
                    end else begin
                        s_d.idx  = s_q.idx - IDX_W'(1);
                        s_d.sreg = s_q.sreg << 1;
                    end
                end else begin
                    s_d.st = SER_IDLE;
                    done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SER_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != SER_IDLE);
    assign sh_clk   = edge_fall ^ ((s_q.st == SER_SHIFT) & s_q.ph);
    assign sh_data  = (s_q.st == SER_SHIFT) & s_q.sreg[DATA_W-1];
    assign sh_store = (s_q.st == SER_STORE);
endmodule

// File: rtl/stp_led_ctrl.sv
module stp_led_ctrl #(
    parameter int GROUPS = 3,
    parameter int GRP_W  = 8,
    parameter int CLK_HZ = 50_000_000,
    parameter int HALF   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  modem_sts,
    input  logic [1:0]  phy1_sts,
    input  logic [1:0]  phy2_sts,
    output logic        sh_clk,
    output logic        sh_data,
    output logic        sh_store
);
    localparam int DATA_W = GROUPS * GRP_W;
    localparam int IDX_W  = $clog2(DATA_W + 1);

    logic              cfg_sw, cfg_edge, cfg_auto;
    logic [1:0]        cfg_modem, cfg_phy1, cfg_phy2, cfg_rate;
    logic [GROUPS-1:0] cfg_groups;
    logic [DATA_W-1:0] cfg_image, hw_val, hw_own, image;
    logic [IDX_W-1:0]  nbits;
    logic              ser_busy, ser_done, tick;

    function automatic logic [IDX_W-1:0] frame_bits(input logic [GROUPS-1:0] g);
        logic [IDX_W-1:0] n;
        n = '0;
        for (int i = 0; i < GROUPS; i++) begin
            if (g[i]) n = IDX_W'((i + 1) * GRP_W);
        end
        return n;
    endfunction

    stp_regs #(.GROUPS(GROUPS), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(ser_busy),
        .done(ser_done), .cfg_sw(cfg_sw), .cfg_edge(cfg_edge),
        .cfg_modem(cfg_modem), .cfg_phy1(cfg_phy1), .cfg_phy2(cfg_phy2),
        .cfg_groups(cfg_groups), .cfg_auto(cfg_auto), .cfg_rate(cfg_rate),
        .cfg_image(cfg_image)
    );

    stp_auto_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(cfg_auto), .rate(cfg_rate), .tick(tick)
    );

    always_comb begin
        hw_val      = '0;
        hw_own      = '0;
        hw_val[1:0] = modem_sts;
        hw_own[1:0] = cfg_modem;
        hw_val[3:2] = phy1_sts;
        hw_own[3:2] = cfg_phy1;
        hw_val[6:5] = phy2_sts;
        hw_own[6:5] = cfg_phy2;
        image       = (cfg_image & ~hw_own) | (hw_val & hw_own);
        nbits       = frame_bits(cfg_groups);
    end

    stp_serializer #(.DATA_W(DATA_W), .HALF(HALF)) u_ser (
        .clk(clk), .rst_n(rst_n), .start(cfg_sw | tick), .image(image),
        .nbits(nbits), .edge_fall(cfg_edge), .busy(ser_busy), .done(ser_done),
        .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store)
    );
endmodule

// File: rtl/stp_led_ctrl_chk.sv
module stp_led_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_wr,
    input logic sh_clk,
    input logic sh_data,
    input logic sh_store,
    input logic busy,
    input logic edge_fall,
    input logic sw_req
);
    AST_STORE_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> (sh_clk == edge_fall));                          // R4
    AST_STORE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_store) |=> sh_store);                                // R4
    AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> busy);                                           // R2
    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(bus_wr)) |-> !sw_req);                 // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sh_store && (sh_clk == edge_fall)));              // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sh_clk != edge_fall) && $past(sh_clk != edge_fall))
        |-> $stable(sh_data));                                        // R10
endmodule

bind stp_led_ctrl stp_led_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .sh_clk(sh_clk),
    .sh_data(sh_data), .sh_store(sh_store), .busy(ser_busy),
    .edge_fall(cfg_edge), .sw_req(cfg_sw)
);

// File: tb/tb_stp_led_ctrl.sv
module tb_stp_led_ctrl;
    localparam int CLK_HZ = 400;
    localparam int HALF   = 1;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  modem_sts = '0, phy1_sts = '0, phy2_sts = '0;
    logic        sh_clk, sh_data, sh_store;

    stp_led_ctrl #(.CLK_HZ(CLK_HZ), .HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modem_sts(modem_sts),
        .phy1_sts(phy1_sts), .phy2_sts(phy2_sts), .sh_clk(sh_clk),
        .sh_data(sh_data), .sh_store(sh_store)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard queues, filled by the driver
    int          q_len[$];
    logic [23:0] q_val[$];
    string       q_req[$];
    int          auto_len = 8;
    logic [23:0] auto_val = '0;
    bit          edge_fall_tb = 1'b0;

    // monitor state
    int          bit_cnt = 0, last_edge = 0, store_cnt = 0, store_t = 0, prev_store_t = 0, store_w = 0;
    logic [23:0] bits = '0;
    bit          gap_bad = 1'b0, p_clk = 1'b0, p_store = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (edge_fall_tb ? (p_clk && !sh_clk) : (!p_clk && sh_clk)) begin
                if (bit_cnt > 0 && (cyc - last_edge) != 2 * HALF) gap_bad = 1'b1;
                bits      = {bits[22:0], sh_data};
                bit_cnt   = bit_cnt + 1;
                last_edge = cyc;
            end
            if (sh_store && !p_store) begin
                int          el;
                logic [23:0] ev;
                string       er;
                if (q_len.size() > 0) begin
                    el = q_len.pop_front(); ev = q_val.pop_front(); er = q_req.pop_front();
                end else begin
                    el = auto_len; ev = auto_val; er = "R8 auto frame";
                end
                check(bit_cnt == el, {er, " length"}, bit_cnt, el);
                check(bits == ev, {er, " value"}, bits, ev);
                check(!gap_bad, "R10 bit spacing", gap_bad, 0);
                check((cyc - last_edge) == HALF, "R4 store delay", cyc - last_edge, HALF);
                prev_store_t = store_t;
                store_t      = cyc;
                store_cnt    = store_cnt + 1;
                bit_cnt = 0; bits = '0; gap_bad = 1'b0; store_w = 0;
            end
            if (sh_store) store_w = store_w + 1;
            if (!sh_store && p_store) check(store_w == 2 * HALF, "R4 store width", store_w, 2 * HALF);
            p_clk   = sh_clk;
            p_store = sh_store;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic sw_frame(input logic [31:0] c1, input logic [31:0] dat, input logic [31:0] c0,
                            input int len, input logic [23:0] expv, input string req);
        logic [31:0] r;
        int n;
        wr(3'd1, c1);
        wr(3'd2, dat);
        q_len.push_back(len); q_val.push_back(expv); q_req.push_back(req);
        wr(3'd0, c0 | 32'h8000_0000);
        rd(3'd4, r);
        check(r[0] == 1'b1, "R2 busy flag", r, 1);
        n = 0;
        do begin rd(3'd4, r); n++; end while (r[0] && n < 2000);
        rd(3'd0, r);
        check(r[31] == 1'b0, "R2 request self-clear", r[31], 0);
    endtask

    task automatic wait_stores(input int n);
        int base = store_cnt;
        while (store_cnt < base + n) @(negedge clk);
    endtask

    task automatic auto_rate(input logic [1:0] rate, input logic [2:0] grp, input int len, input int period, input string req);
        wr(3'd1, 32'h0000_0001);
        repeat (60) @(negedge clk);
        auto_len = len;
        wr(3'd1, 32'h8000_0000 | (32'(rate) << 23) | 32'(grp));
        wait_stores(3);
        check((store_t - prev_store_t) == period, req, store_t - prev_store_t, period);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int base;
        // R1 reset values while reset is held
        rd(3'd0, r); check(r == 32'h8000_0000, "R1 ctrl0 reset", r, 32'h8000_0000);
        rd(3'd1, r); check(r == 0, "R1 ctrl1 reset", r, 0);
        rd(3'd2, r); check(r == 0, "R1 data0 reset", r, 0);
        rd(3'd3, r); check(r == 0, "R1 data1 reset", r, 0);
        rd(3'd4, r); check(r == 0, "R1 status reset", r, 0);
        check(sh_store == 1'b0, "R1 store low", sh_store, 0);
        @(negedge clk); rst_n = 1'b1;
        // R3: no group enabled -> request clears, no frame
        repeat (5) @(negedge clk);
        rd(3'd0, r); check(r[31] == 1'b0, "R3 empty request clears", r[31], 0);
        check(store_cnt == 0, "R3 no frame without groups", store_cnt, 0);
        check(sh_clk == 1'b0, "R5 rising-mode idle low", sh_clk, 0);

        sw_frame(32'h1, 32'hA5, 32'h0, 8, 24'hA5, "R4 msb-first 8-bit");
        sw_frame(32'h3, 32'hABCD12, 32'h0, 16, 24'hCD12, "R3 two groups");
        sw_frame(32'h4, 32'hABCD12, 32'h0, 24, 24'hABCD12, "R3 highest group 24-bit");
        edge_fall_tb = 1'b1;
        sw_frame(32'h1, 32'h3C, 32'h0400_0000, 8, 24'h3C, "R5 falling edge frame");
        check(sh_clk == 1'b1, "R5 falling-mode idle high", sh_clk, 1);
        edge_fall_tb = 1'b0;
        modem_sts = 2'b01;
        sw_frame(32'h1, 32'hFF, 32'h0300_0000, 8, 24'hFD, "R6 modem takeover");
        modem_sts = 2'b11;
        sw_frame(32'h1, 32'h00, 32'h0, 8, 24'h00, "R6 modem not owned");
        phy1_sts = 2'b10; phy2_sts = 2'b11;
        sw_frame(32'h0001_8001, 32'h81, 32'h1800_0000, 8, 24'hE9, "R7 phy takeover");

        // automatic updates
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h5A);
        auto_val = 24'h5A;
        auto_rate(2'd3, 3'b001, 8, CLK_HZ / 10, "R8 rate code 3 period");
        auto_rate(2'd2, 3'b001, 8, CLK_HZ / 8, "R8 rate code 2 period");
        auto_rate(2'd0, 3'b001, 8, CLK_HZ / 2, "R8 rate code 0 period");
        auto_rate(2'd3, 3'b100, 24, 2 * (CLK_HZ / 10), "R9 busy tick dropped");
        wr(3'd1, 32'h4000_0001);
        repeat (60) @(negedge clk);
        base = store_cnt;
        repeat (500) @(negedge clk);
        check(store_cnt == base, "R8 other source no updates", store_cnt, base);
        check(q_len.size() == 0, "R2 all frames seen", q_len.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule